// File: doc/BRIEF.md
# Sprite and Bit-Plane Collision Detector

This block records pixel-level overlaps while a frame is drawn. On every pixel the display pipeline marks as valid, it takes one presence flag for each of eight sprites and the six bit-plane bits of that pixel. The sprites are merged into four pairs. The planes are split into an odd set (planes 1, 3, 5) and an even set (planes 2, 4, 6). Any overlap among these six objects sets a sticky bit in a 16-bit status word.

Software programs a write-only 16-bit setup word. This word picks which odd sprites join their pair, which planes take part in matching, and the value each plane must hold. Reading the status word returns the bits gathered so far and clears them in the same cycle. A collision that arrives in the read cycle is kept for the next read. The plane grouping is the same in single and dual playfield modes, so the block has no mode input.

Top module: `clx_detector`

## Requirements
- R1: After reset, both the status word and the setup word are zero, so `stat_rdata` reads 0.
- R2: Status bits 14 down to 9 flag sprite-pair overlaps 2/3, 1/3, 1/2, 0/3, 0/2 and 0/1. Pair k is sprites 2k and 2k+1. Bit 15 always reads 0.
- R3: Status bits 5 to 8 flag the even plane set against pairs 0 to 3. Bits 1 to 4 flag the odd plane set against pairs 0 to 3.
- R4: Status bit 0 flags a pixel where the even and odd plane sets both match.
- R5: Setup bits 12 to 15 add sprites 1, 3, 5 and 7 into pairs 0 to 3. The even sprite of a pair always counts.
- R6: Setup bits 6 to 11 enable planes 1 to 6, and setup bits 0 to 5 give their match values. A set matches when every enabled plane in it equals its match value.
- R7: A plane set with all of its planes disabled matches on every valid pixel.
- R8: Status bits are sticky. New collisions are ORed in only on cycles where `pix_valid` is high.
- R9: When `stat_rd` is high, `stat_rdata` shows the word gathered before that cycle. The word then clears, except for collisions from that same cycle, which are kept.
- R10: A setup write takes effect from the next cycle. A pixel in the write cycle uses the old setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Current pixel inputs are valid |
| spr_on | input | 8 | Sprite presence flags, bit n = sprite n |
| plane_bits | input | 6 | Plane bits, bit n = plane n+1 |
| ctl_wr | input | 1 | Setup word write strobe |
| ctl_wdata | input | 16 | Setup word write data |
| stat_rd | input | 1 | Status read strobe (clears the word) |
| stat_rdata | output | 16 | Status word |

## Verification
The bench builds the block with its default parameters: eight sprites, six planes and 16-bit registers. With these values every status position and every setup bit is reachable, so random setup words exercise each plane enable, match polarity and odd-sprite merge. Directed steps reach the cases where all planes are disabled, a setup write coincides with a pixel, and a read coincides with a collision.

// File: rtl/clx_pkg.sv
package clx_pkg;
    localparam int REG_W   = 16;
    localparam int NPAIRS  = 4;
    // status positions
    localparam int ST_PLPL   = 0;
    localparam int ST_ODD0   = 1;
    localparam int ST_EVEN0  = 5;
    localparam int ST_SPR0   = 9;
    // setup positions
    localparam int CF_MV0    = 0;
    localparam int CF_EN0    = 6;
    localparam int CF_ODDSP0 = 12;
endpackage

// File: rtl/clx_pair_merge.sv
module clx_pair_merge #(
    parameter int SPR_N = 8,
    localparam int GRP_N = SPR_N / 2
) (
    input  logic [SPR_N-1:0] spr_on,
    input  logic [GRP_N-1:0] odd_join,
    output logic [GRP_N-1:0] grp_on
);
    for (genvar g = 0; g < GRP_N; g++) begin : g_pair
        assign grp_on[g] = spr_on[2*g] | (odd_join[g] & spr_on[2*g+1]);
    end
endmodule

// File: rtl/clx_plane_match.sv
module clx_plane_match #(
    parameter int PL_N  = 6,
    parameter int FIRST = 0,
    localparam int SET_N = PL_N / 2
) (
    input  logic [PL_N-1:0] plane_bits,
    input  logic [PL_N-1:0] plane_en,
    input  logic [PL_N-1:0] match_val,
    output logic            set_hit
);
    logic [SET_N-1:0] ok;
    for (genvar i = 0; i < SET_N; i++) begin : g_pl
        localparam int IDX = FIRST + 2*i;
        assign ok[i] = ~plane_en[IDX] | (plane_bits[IDX] == match_val[IDX]);
    end
    assign set_hit = &ok;
endmodule

// File: rtl/clx_hit_map.sv
module clx_hit_map
    import clx_pkg::*;
(
    input  logic [NPAIRS-1:0] grp_on,
    input  logic              odd_hit,
    input  logic              even_hit,
    output logic [REG_W-1:0]  hits
);
    always_comb begin
        hits = '0;
        hits[ST_PLPL] = odd_hit & even_hit;
        for (int g = 0; g < NPAIRS; g++) begin
            hits[ST_ODD0 + g]  = odd_hit  & grp_on[g];
            hits[ST_EVEN0 + g] = even_hit & grp_on[g];
        end
        hits[ST_SPR0 + 0] = grp_on[0] & grp_on[1];
        hits[ST_SPR0 + 1] = grp_on[0] & grp_on[2];
        hits[ST_SPR0 + 2] = grp_on[0] & grp_on[3];
        hits[ST_SPR0 + 3] = grp_on[1] & grp_on[2];
        hits[ST_SPR0 + 4] = grp_on[1] & grp_on[3];
        hits[ST_SPR0 + 5] = grp_on[2] & grp_on[3];
    end
endmodule

// File: rtl/clx_detector.sv
module clx_detector
    import clx_pkg::*;
#(
    parameter int SPR_N = 8,
    parameter int PL_N  = 6,
    localparam int GRP_N = SPR_N / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [SPR_N-1:0] spr_on,
    input  logic [PL_N-1:0]  plane_bits,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             stat_rd,
    output logic [REG_W-1:0] stat_rdata
);
    logic [REG_W-1:0] setup_q;
    logic [REG_W-1:0] stat_q;
    logic [GRP_N-1:0] grp_on;
    logic             odd_hit, even_hit;
    logic [REG_W-1:0] hits;

    clx_pair_merge #(.SPR_N(SPR_N)) u_merge (
        .spr_on   (spr_on),
        .odd_join (setup_q[CF_ODDSP0 +: GRP_N]),
        .grp_on   (grp_on)
    );

    clx_plane_match #(.PL_N(PL_N), .FIRST(0)) u_odd (
        .plane_bits (plane_bits),
        .plane_en   (setup_q[CF_EN0 +: PL_N]),
        .match_val  (setup_q[CF_MV0 +: PL_N]),
        .set_hit    (odd_hit)
    );

    clx_plane_match #(.PL_N(PL_N), .FIRST(1)) u_even (
        .plane_bits (plane_bits),
        .plane_en   (setup_q[CF_EN0 +: PL_N]),
        .match_val  (setup_q[CF_MV0 +: PL_N]),
        .set_hit    (even_hit)
    );

    clx_hit_map u_map (
        .grp_on   (grp_on),
        .odd_hit  (odd_hit),
        .even_hit (even_hit),
        .hits     (hits)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
        end else if (ctl_wr) begin
            setup_q <= ctl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_rd ? '0 : stat_q) | (pix_valid ? hits : '0);
        end
    end

    assign stat_rdata = stat_q;
endmodule

// File: rtl/clx_detector_chk.sv
module clx_detector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_valid,
    input logic [7:0]  spr_on,
    input logic        stat_rd,
    input logic [15:0] stat_rdata
);
    p_bit15_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[15] == 1'b0);

    p_pair01_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && spr_on[0] && spr_on[2]) |=> stat_rdata[9]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !pix_valid) |=> $stable(stat_rdata));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !pix_valid) |=> (stat_rdata == 16'h0000));
endmodule

bind clx_detector clx_detector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .spr_on     (spr_on),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata)
);

// File: tb/tb_clx_detector.sv
module tb_clx_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  spr_on = '0;
    logic [5:0]  plane_bits = '0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [15:0] stat_rdata;

    int vec = 0;
    int bad = 0;
    logic [15:0] m_ctl  = '0;
    logic [15:0] m_stat = '0;
    bit done = 0;

    always #2 clk = ~clk;

    clx_detector dut (.*);

    function automatic logic [15:0] ref_hits(logic [15:0] c, logic [7:0] s, logic [5:0] p);
        logic [3:0] g;
        logic odd_m, even_m;
        logic [15:0] h;
        for (int k = 0; k < 4; k++) g[k] = s[2*k] | (c[12+k] & s[2*k+1]);
        odd_m = 1'b1; even_m = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (c[6+k] && (p[k] != c[k])) begin
                if (k % 2 == 0) odd_m = 1'b0; else even_m = 1'b0;
            end
        end
        h = '0;
        h[0] = odd_m & even_m;
        for (int k = 0; k < 4; k++) begin
            h[1+k] = odd_m & g[k];
            h[5+k] = even_m & g[k];
        end
        h[9]  = g[0] & g[1];
        h[10] = g[0] & g[2];
        h[11] = g[0] & g[3];
        h[12] = g[1] & g[2];
        h[13] = g[1] & g[3];
        h[14] = g[2] & g[3];
        return h;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: stat_rdata=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge: drive, advance model, wait one cycle, compare
    task automatic step(string tag, bit wr, logic [15:0] wd, bit rd,
                        bit v, logic [7:0] s, logic [5:0] p);
        ctl_wr = wr; ctl_wdata = wd; stat_rd = rd;
        pix_valid = v; spr_on = s; plane_bits = p;
        if (rd) check(tag, stat_rdata, m_stat);
        m_stat = (rd ? 16'h0 : m_stat) | (v ? ref_hits(m_ctl, s, p) : 16'h0);
        if (wr) m_ctl = wd;
        @(negedge clk);
        check(tag, stat_rdata, m_stat);
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset status", stat_rdata, 16'h0);
        // R1: setup zero means all planes disabled -> bit0 on first pixel
        step("R1 R7 all planes disabled", 0, 0, 0, 1, 8'h00, 6'h15);
        check("R7 plane-vs-plane bit", stat_rdata, 16'h0001);
        step("R9 read clears", 0, 0, 1, 0, 8'h00, 6'h00);
        check("R9 cleared", stat_rdata, 16'h0000);
        // R10: write all-enabled, match 0; pixel in same cycle uses old setup
        step("R10 write with pixel", 1, 16'h0FC0, 0, 1, 8'h01, 6'h3F);
        check("R10 old setup used", stat_rdata, 16'h0023);
        step("R9 read", 0, 0, 1, 0, 0, 0);
        // R2: sprites 0 and 2, planes mismatched
        step("R2 pair 0/1", 0, 0, 0, 1, 8'h05, 6'h3F);
        check("R2 bit9 only", stat_rdata, 16'h0200);
        step("R9 read", 0, 0, 1, 0, 0, 0);
        // R5: sprite 1 excluded, then joined
        step("R5 odd sprite excluded", 0, 0, 0, 1, 8'h06, 6'h3F);
        check("R5 no pair hit", stat_rdata, 16'h0000);
        step("R5 enable sprite1", 1, 16'h1FC0, 0, 0, 0, 0);
        step("R5 odd sprite joined", 0, 0, 0, 1, 8'h06, 6'h3F);
        check("R5 bit9 set", stat_rdata, 16'h0200);
        // R3 R6: odd planes match (planes 1,3,5 = 0), even mismatch
        step("R3 R6 odd set vs pair 3", 0, 0, 1, 1, 8'h40, 6'h2A);
        check("R3 bit4", stat_rdata, 16'h0010);
        step("R3 R6 even set vs pair 2", 0, 0, 1, 1, 8'h10, 6'h15);
        check("R3 bit7", stat_rdata, 16'h0080);
        // R4: both sets match; R9 same-cycle collision kept
        step("R4 R9 read with hit", 0, 0, 1, 1, 8'h00, 6'h00);
        check("R4 bit0 kept", stat_rdata, 16'h0001);
        // R8: idle cycles keep value
        step("R8 hold", 0, 0, 0, 0, 8'hFF, 6'h00);
        check("R8 no change without valid", stat_rdata, 16'h0001);
        // R7: only odd planes enabled with mismatch, even set disabled
        step("R7 even set disabled", 1, 16'h0540, 1, 0, 0, 0);
        step("R7 even set matches", 0, 0, 0, 1, 8'h01, 6'h01);
        check("R7 bit5", stat_rdata, 16'h0020);
        // random mix for R2..R9
        for (int i = 0; i < 3000; i++) begin
            bit wr = ($urandom % 8) == 0;
            bit rd = ($urandom % 6) == 0;
            bit v  = ($urandom % 4) != 0;
            logic [7:0]  s = 8'($urandom) & 8'($urandom);
            logic [5:0]  p = 6'($urandom);
            logic [15:0] w = 16'($urandom);
            step("R8 R9 random", wr, w, rd, v, s, p);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule